// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master with Configurable Parity

This block is the master end of a 32-bit bus on which address and data share the same lines. Internal logic hands it one transfer at a time. Each transfer has a start address, a direction and a burst-size code. The block then spends one clock on the address and one clock on each data word. During that time it drives the burst-size code pins and, for outgoing words, the parity lines.

Parity is set at run time through a small mode register. The register selects three things: whether parity is on, whether it is odd or even, and whether it is kept per byte lane or once for the whole word. In whole-word mode the single parity line used turns around with the phase. It is an output while the block drives the bus and an input while read data comes back. Read data is compared against a locally computed parity, and a mismatch is reported as a one-cycle pulse together with the beat index.

The bus pins are modelled as separate out, in and enable signals. An active-low force-off input drops every enable without stopping the transfer.

Top module: `mux_bus_master`

## Requirements
- R1: A request is accepted on a clock where the block is idle and `req_valid` is high. The first busy cycle is the address phase: `ad_o` equals the latched address, `ad_oe` is high, and there is no data beat. A run of data beats follows, one per clock, whose length is set by the size code.
- R2: `size_o` carries the accepted size code for every busy cycle and reads 000 when idle. The codes and data-beat counts are: 000 = 1, 001 = 2, 010 = 4, 011 = 8, 100 = 16, 101 = 12, 111 = 1. Code 110 never appears on `size_o`.
- R3: When the block is idle, `ad_oe` and all `par_oe` bits are low. They return low on the clock after the last data beat.
- R4: While `oe_n` is high, `ad_oe` and `par_oe` are all low in every phase, and the transfer still sequences normally.
- R5: `cfg_mode` is loaded by `cfg_we` while the block is idle. Bit 0 enables parity, bit 1 selects odd parity (0 = even), and bit 2 selects per-byte coverage (0 = whole word). A `cfg_we` pulse while the block is busy has no effect.
- R6: In per-byte mode, parity bit i covers `ad[8i+7:8i]`, so bit 3 covers the top byte. The bit is the XOR of the byte, inverted when odd parity is selected. All four parity bits are driven during the address phase and write beats and are not driven during read beats.
- R7: In whole-word mode, only parity bit 3 is used, and it equals the XOR of all 32 bits (inverted for odd parity). It is driven during the address phase and write beats and sampled as input on read beats. Parity bits 2 to 0 are never driven in this mode.
- R8: With parity disabled, no parity line is driven and no parity error is reported.
- R9: On a read beat with parity enabled, a mismatch between `par_i` and the parity computed from `ad_i` raises `perr_pulse` for exactly one clock, on the clock after that beat. `perr_beat` gives the beat index.
- R10: Size code 111 is a receive-side alignment transfer. It has one data beat, which is always a read, even when `req_write` is high, and `size_o` shows 111.
- R11: A request carrying size code 110 is ignored: the block stays idle and drives nothing.
- R12: On a write beat, `wr_take` is high and `ad_o` equals `wr_data`. On a read beat, `rd_valid` is high and `rd_data` equals `ad_i`. On both, `beat_idx` counts from 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Parity mode register write strobe |
| cfg_mode | input | 3 | Mode value: [0] enable, [1] odd, [2] per-byte |
| req_valid | input | 1 | Transfer request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Burst-size code |
| req_addr | input | 32 | Start address |
| busy | output | 1 | Transfer in progress |
| wr_data | input | 32 | Write word for the current beat |
| wr_take | output | 1 | Current beat consumes `wr_data` |
| rd_data | output | 32 | Read word of the current beat |
| rd_valid | output | 1 | Current beat is a read beat |
| beat_idx | output | 4 | Index of the current data beat |
| perr_pulse | output | 1 | Read parity mismatch on the previous beat |
| perr_beat | output | 4 | Beat index of the mismatch |
| oe_n | input | 1 | Active-low force-off for bus drivers |
| ad_o | output | 32 | Address/data out |
| ad_i | input | 32 | Address/data in |
| ad_oe | output | 1 | Address/data driver enable |
| par_o | output | 4 | Parity out |
| par_i | input | 4 | Parity in |
| par_oe | output | 4 | Parity driver enables, one per line |
| size_o | output | 3 | Burst-size code pins |

## Verification
Several rules are checked on every clock. The force-off input keeps every driver off. No driver is on while idle, and a read beat never drives the address/data lines. Code 110 never reaches the size pins and a request carrying it never starts a transfer. The first busy cycle is never a data beat, whole-word mode never drives the lower parity lines, disabled parity drives nothing, and every error pulse follows a read beat. Only the bench's sweep shows the rest. That covers the exact parity values per lane and sense, the beat counts for each code, the address and data values, the beat index carried by an error, and a mode write landing during a transfer being dropped.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int BEAT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } st_e;

    typedef struct packed {
        logic byte_mode;
        logic odd;
        logic en;
    } pmode_t;

    localparam logic [2:0] SZ_RSVD  = 3'b110;
    localparam logic [2:0] SZ_ALIGN = 3'b111;

    // Index of the last data beat for a size code.
    function automatic logic [BEAT_W-1:0] last_beat_of(input logic [2:0] code);
        logic [BEAT_W-1:0] r;
        case (code)
            3'b001:  r = BEAT_W'(1);
            3'b010:  r = BEAT_W'(3);
            3'b011:  r = BEAT_W'(7);
            3'b100:  r = BEAT_W'(15);
            3'b101:  r = BEAT_W'(11);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mbm_parity.sv
module mbm_parity #(
    parameter int DW    = 32,
    localparam int LANES = DW / 8
) (
    input  logic [DW-1:0]    data,
    input  logic             odd,
    output logic [LANES-1:0] lane_par,
    output logic             word_par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_par[g] = (^data[8*g +: 8]) ^ odd;
    end
    assign word_par = (^data) ^ odd;
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_size,
    input  logic [DW-1:0]     req_addr,
    output st_e               st,
    output logic [DW-1:0]     addr,
    output logic              wr,
    output logic [2:0]        code,
    output logic [BEAT_W-1:0] beat,
    output pmode_t            mode
);
    typedef struct packed {
        st_e               st;
        logic [DW-1:0]     addr;
        logic              wr;
        logic [2:0]        code;
        logic [BEAT_W-1:0] last;
        logic [BEAT_W-1:0] beat;
        pmode_t            mode;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (cfg_we) begin
                    s_d.mode = pmode_t'(cfg_mode);
                end
                if (req_valid && (req_size != SZ_RSVD)) begin
                    s_d.st   = ST_ADDR;
                    s_d.addr = req_addr;
                    s_d.wr   = req_write && (req_size != SZ_ALIGN);
                    s_d.code = req_size;
                    s_d.last = last_beat_of(req_size);
                    s_d.beat = '0;
                end
            end
            ST_ADDR: begin
                s_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (s_q.beat == s_q.last) begin
                    s_d.st   = ST_IDLE;
                    s_d.code = '0;
                    s_d.beat = '0;
                end else begin
                    s_d.beat = s_q.beat + BEAT_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, addr: '0, wr: 1'b0, code: '0,
                     last: '0, beat: '0, mode: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign st   = s_q.st;
    assign addr = s_q.addr;
    assign wr   = s_q.wr;
    assign code = s_q.code;
    assign beat = s_q.beat;
    assign mode = s_q.mode;
endmodule

// File: rtl/mbm_perr.sv
module mbm_perr
    import mbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              mismatch,
    input  logic [BEAT_W-1:0] beat,
    output logic              pulse,
    output logic [BEAT_W-1:0] pulse_beat
);
    typedef struct packed {
        logic              hit;
        logic [BEAT_W-1:0] idx;
    } perr_t;

    perr_t e_d, e_q;

    always_comb begin
        e_d     = e_q;
        e_d.hit = chk_valid && mismatch;
        if (chk_valid && mismatch) begin
            e_d.idx = beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign pulse      = e_q.hit;
    assign pulse_beat = e_q.idx;
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int DW = 32,
    localparam int LANES = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_size,
    input  logic [DW-1:0]     req_addr,
    output logic              busy,
    input  logic [DW-1:0]     wr_data,
    output logic              wr_take,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              perr_pulse,
    output logic [BEAT_W-1:0] perr_beat,
    input  logic              oe_n,
    output logic [DW-1:0]     ad_o,
    input  logic [DW-1:0]     ad_i,
    output logic              ad_oe,
    output logic [LANES-1:0]  par_o,
    input  logic [LANES-1:0]  par_i,
    output logic [LANES-1:0]  par_oe,
    output logic [2:0]        size_o
);
    st_e               st;
    logic [DW-1:0]     addr_q;
    logic              wr_q;
    logic [BEAT_W-1:0] beat_q;
    pmode_t            mode_q;

    mbm_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .st        (st),
        .addr      (addr_q),
        .wr        (wr_q),
        .code      (size_o),
        .beat      (beat_q),
        .mode      (mode_q)
    );

    logic in_addr, in_data, drive_out;
    assign in_addr   = (st == ST_ADDR);
    assign in_data   = (st == ST_DATA);
    assign drive_out = in_addr || (in_data && wr_q);

    assign busy     = (st != ST_IDLE);
    assign wr_take  = in_data && wr_q;
    assign rd_valid = in_data && !wr_q;
    assign rd_data  = ad_i;
    assign beat_idx = beat_q;

    always_comb begin
        if (in_addr)      ad_o = addr_q;
        else if (wr_take) ad_o = wr_data;
        else              ad_o = '0;
    end
    assign ad_oe = drive_out && !oe_n;

    // outgoing parity
    logic [LANES-1:0] gen_lane;
    logic             gen_word;
    mbm_parity #(.DW(DW)) u_gen (
        .data     (ad_o),
        .odd      (mode_q.odd),
        .lane_par (gen_lane),
        .word_par (gen_word)
    );

    localparam logic [LANES-1:0] TOP_ONLY = {1'b1, {(LANES-1){1'b0}}};

    always_comb begin
        if (mode_q.byte_mode) par_o = gen_lane;
        else                  par_o = {gen_word, {(LANES-1){1'b0}}};
        if (mode_q.en && drive_out && !oe_n)
            par_oe = mode_q.byte_mode ? {LANES{1'b1}} : TOP_ONLY;
        else
            par_oe = '0;
    end

    // incoming parity check
    logic [LANES-1:0] chk_lane;
    logic             chk_word;
    logic             mismatch;
    mbm_parity #(.DW(DW)) u_chk_par (
        .data     (ad_i),
        .odd      (mode_q.odd),
        .lane_par (chk_lane),
        .word_par (chk_word)
    );
    assign mismatch = mode_q.byte_mode ? (|(chk_lane ^ par_i))
                                       : (chk_word ^ par_i[LANES-1]);

    mbm_perr u_perr (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (rd_valid && mode_q.en),
        .mismatch   (mismatch),
        .beat       (beat_q),
        .pulse      (perr_pulse),
        .pulse_beat (perr_beat)
    );
endmodule

// File: rtl/mbm_chk.sv
module mbm_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oe_n,
    input logic             busy,
    input logic             ad_oe,
    input logic [LANES-1:0] par_oe,
    input logic [2:0]       size_o,
    input logic             rd_valid,
    input logic             wr_take,
    input logic             perr_pulse,
    input logic             req_valid,
    input logic [2:0]       req_size,
    input logic             mode_en,
    input logic             mode_byte
);
    // R4
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!ad_oe && par_oe == '0));

    // R3
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ad_oe && par_oe == '0));

    // R2
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_o != 3'b110);

    // R12
    rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!ad_oe && !wr_take));

    // R1
    addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!rd_valid && !wr_take && size_o != 3'b000 || !rd_valid && !wr_take));

    // R7
    word_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_byte |-> (par_oe[LANES-2:0] == '0));

    // R8
    par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> (par_oe == '0));

    // R9
    perr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_pulse |-> $past(rd_valid));

    // R11
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_size == 3'b110) |=> !busy);
endmodule

bind mux_bus_master mbm_chk #(.LANES(LANES)) u_mbm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_n       (oe_n),
    .busy       (busy),
    .ad_oe      (ad_oe),
    .par_oe     (par_oe),
    .size_o     (size_o),
    .rd_valid   (rd_valid),
    .wr_take    (wr_take),
    .perr_pulse (perr_pulse),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .mode_en    (mode_q.en),
    .mode_byte  (mode_q.byte_mode)
);

// File: tb/mux_bus_master_tb.sv
module mux_bus_master_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_addr = '0;
    logic        busy;
    logic [31:0] wr_data = '0;
    logic        wr_take;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [3:0]  beat_idx;
    logic        perr_pulse;
    logic [3:0]  perr_beat;
    logic        oe_n = 1'b0;
    logic [31:0] ad_o;
    logic [31:0] ad_i = '0;
    logic        ad_oe;
    logic [3:0]  par_o;
    logic [3:0]  par_i = '0;
    logic [3:0]  par_oe;
    logic [2:0]  size_o;

    mux_bus_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .busy(busy), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .beat_idx(beat_idx),
        .perr_pulse(perr_pulse), .perr_beat(perr_beat), .oe_n(oe_n),
        .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe), .par_o(par_o), .par_i(par_i),
        .par_oe(par_oe), .size_o(size_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_beats(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b100: return 16;
            3'b101: return 12;
            3'b111: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] exp_par(input logic [31:0] d, input bit odd,
                                           input bit bytem);
        logic [3:0] p;
        if (bytem) begin
            for (int i = 0; i < 4; i++) p[i] = (^d[8*i +: 8]) ^ odd;
        end else begin
            p = {(^d) ^ odd, 3'b000};
        end
        return p;
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] seed, input int b);
        return seed ^ (32'h0100_0193 * 32'(b + 1)) ^ 32'h5A3C_96E1;
    endfunction

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_mode = m;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // One transfer; mode m must already be loaded. cb: beat to corrupt (-1 none).
    task automatic run_xfer(input logic [2:0] code, input bit wr, input logic [2:0] m,
                            input bit oen, input int cb, input bit poke);
        bit         en    = m[0];
        bit         odd   = m[1];
        bit         bytem = m[2];
        bit         eff_wr = wr && (code != 3'b111);
        int         n     = exp_beats(code);
        logic [31:0] a    = 32'h1000_0000 ^ {code, wr, m, oen, 24'h00A5_5A};
        logic [3:0] oe_mask;
        logic [3:0] ep;
        bit         prev_err = 1'b0;
        int         prev_b = 0;

        @(negedge clk);
        // R9 pulse lasts one clock; R3 idle between transfers
        check(perr_pulse == 1'b0, "R9 pulse single cycle", 32'(perr_pulse), 0);
        check(busy == 1'b0 && ad_oe == 1'b0 && par_oe == 4'h0, "R3 idle hi-z",
              {busy, ad_oe, par_oe}, 0);
        check(size_o == 3'b000, "R2 idle size", 32'(size_o), 0);
        oe_n      = oen;
        req_valid = 1'b1;
        req_write = wr;
        req_size  = code;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (code == 3'b110) begin
            check(busy == 1'b0 && ad_oe == 1'b0 && size_o == 3'b000,
                  "R11 reserved code ignored", {busy, ad_oe, size_o}, 0);
            oe_n = 1'b0;
            return;
        end
        oe_mask = (!en || oen) ? 4'h0 : (bytem ? 4'hF : 4'h8);
        // R1 address phase
        check(busy && !rd_valid && !wr_take, "R1 address phase", {busy, rd_valid, wr_take}, 3'b100);
        check(ad_o == a, "R1 address value", ad_o, a);
        check(ad_oe == !oen, "R4 ad_oe on address", 32'(ad_oe), 32'(!oen));
        check(size_o == code, "R2 size code", 32'(size_o), 32'(code));
        check(par_oe == oe_mask, "R6 R7 R8 par_oe address", 32'(par_oe), 32'(oe_mask));
        ep = exp_par(a, odd, bytem);
        check((par_o & oe_mask) == (ep & oe_mask), "R6 R7 address parity",
              32'(par_o & oe_mask), 32'(ep & oe_mask));
        if (poke) begin
            cfg_we   = 1'b1;
            cfg_mode = ~m;
        end
        for (int b = 0; b < n; b++) begin
            logic [31:0] d;
            logic [3:0]  pi;
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
            d = pat(a, b);
            if (eff_wr) begin
                wr_data = d;
            end else begin
                pi = exp_par(d, odd, bytem);
                if (!bytem) pi[2:0] = 3'b101;
                if (b == cb) pi = pi ^ (bytem ? (4'h1 << (b % 4)) : 4'h8);
                ad_i  = d;
                par_i = pi;
            end
            #1;
            // R9 previous beat's error
            check(perr_pulse == prev_err, "R9 perr pulse", 32'(perr_pulse), 32'(prev_err));
            if (prev_err)
                check(perr_beat == 4'(prev_b), "R9 perr beat", 32'(perr_beat), 32'(prev_b));
            check(size_o == code, "R2 size during data", 32'(size_o), 32'(code));
            check(beat_idx == 4'(b), "R12 beat index", 32'(beat_idx), 32'(b));
            if (eff_wr) begin
                check(wr_take && !rd_valid, "R12 write beat", {wr_take, rd_valid}, 2'b10);
                check(ad_o == d, "R12 write data", ad_o, d);
                check(ad_oe == !oen, "R4 ad_oe write", 32'(ad_oe), 32'(!oen));
                check(par_oe == oe_mask, "R6 R7 par_oe write", 32'(par_oe), 32'(oe_mask));
                ep = exp_par(d, odd, bytem);
                check((par_o & oe_mask) == (ep & oe_mask), "R6 R7 write parity",
                      32'(par_o & oe_mask), 32'(ep & oe_mask));
                prev_err = 1'b0;
            end else begin
                check(rd_valid && !wr_take, code == 3'b111 ? "R10 alignment read" : "R12 read beat",
                      {rd_valid, wr_take}, 2'b10);
                check(rd_data == d, "R12 read data", rd_data, d);
                check(ad_oe == 1'b0 && par_oe == 4'h0, "R6 R7 read turnaround",
                      {ad_oe, par_oe}, 0);
                prev_err = en && (b == cb);
            end
            prev_b = b;
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        check(perr_pulse == prev_err, "R9 perr after last beat", 32'(perr_pulse), 32'(prev_err));
        if (prev_err)
            check(perr_beat == 4'(prev_b), "R9 perr last beat index", 32'(perr_beat), 32'(prev_b));
        check(busy == 1'b0 && ad_oe == 1'b0 && par_oe == 4'h0, "R3 release after last beat",
              {busy, ad_oe, par_oe}, 0);
        check(size_o == 3'b000, "R2 size back to idle", 32'(size_o), 0);
        oe_n = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!busy && !ad_oe && par_oe == 4'h0 && size_o == 3'b000 && !perr_pulse,
              "R3 reset state", {busy, ad_oe, par_oe, size_o, perr_pulse}, 0);
        // full sweep: every mode, every code, both directions
        for (int m = 0; m < 8; m++) begin
            set_mode(3'(m));
            for (int c = 0; c < 8; c++) begin
                for (int w = 0; w < 2; w++) begin
                    int cb;
                    cb = (c % 2 == 1) ? exp_beats(3'(c)) - 1 : 0;
                    run_xfer(3'(c), w[0], 3'(m), 1'b0, cb, 1'b0);
                end
            end
        end
        // R4 force-off across phases
        set_mode(3'b101);
        for (int c = 0; c < 3; c++) begin
            run_xfer(3'(c), 1'b1, 3'b101, 1'b1, -1, 1'b0);
            run_xfer(3'(c), 1'b0, 3'b101, 1'b1, 1, 1'b0);
        end
        // R5 mode write during a transfer is dropped
        set_mode(3'b011);
        run_xfer(3'b010, 1'b1, 3'b011, 1'b0, -1, 1'b1);
        run_xfer(3'b010, 1'b0, 3'b011, 1'b0, 2, 1'b0);
        run_xfer(3'b001, 1'b1, 3'b011, 1'b0, -1, 1'b0);
        // R5 idle write takes effect
        set_mode(3'b110);
        run_xfer(3'b011, 1'b0, 3'b110, 1'b0, 3, 1'b0);
        run_xfer(3'b000, 1'b1, 3'b110, 1'b0, -1, 1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule